// File: doc/BRIEF.md
# Serial Control Register Interface

This block is a four-wire serial slave. An external controller uses it to read and write a bank of thirteen byte-wide control registers. The four wires are an active-low select, a shift clock, a serial data input, and a serial data output with a separate drive enable for an external tristate buffer. The block runs on the chip's system clock. It oversamples the shift clock, the select and the data input through two-stage synchronizers, so the shift clock must run well below the system clock.

Each access is a 16-bit frame sent most significant bit first. The frame holds a direction flag, then a 7-bit address, then 8 data bits. The controller may send the frame as one continuous burst or as two byte bursts with the shift clock paused while select stays low. The register contents reach the rest of the chip as combined control bits. Each ordinary bit is ORed with a matching external pin. Register 0 bit 7 is the soft power-down and register 0 bit 6 is the soft coefficient reset. Both are active low, so each is the AND of its pin and its register bit. A power-down returns every register to its default. A coefficient reset only produces its strobe.

Top module: `serial_ctrl_regs`

## Requirements
- R1: Frame bit 0 is the direction flag. Bits 1 to 7 are address A6..A0 and bits 8 to 15 are data B7..B0, each field MSB first and sampled on shift-clock rising edges. A write takes effect at the 16th rising edge. Shift-clock edges after the 16th are ignored until select goes high.
- R2: After rst_ni, every register reads 0x00 except register 0, which reads 0xC0.
- R3: sdo_oe_o is high only during the 8 data bits of a read. It rises on the falling edge after the 8th rising edge. sdo_o presents B7..B0, each updated on a shift-clock falling edge. sdo_oe_o drops on the falling edge after the 16th rising edge, or when select goes high.
- R4: A frame split into two 8-bit bursts, with the shift clock idle and select held low between them, acts exactly like one continuous burst.
- R5: Select going high resets the bit counter. A partial frame then changes no register.
- R6: For every bit except register 0 bits 7 and 6, ctl_o bit (8*i+b) equals register i bit b ORed with ctl_pins_i bit (8*i+b).
- R7: pdn_no and ctl_o[7] equal ctl_pins_i[7] AND register 0 bit 7. crst_no and ctl_o[6] equal ctl_pins_i[6] AND register 0 bit 6.
- R8: While pdn_no is low, every register is reset to its R2 default on the next clock, so writing 0 to register 0 bit 7 clears the bank and releases the strobe itself. A low crst_no leaves the register contents unchanged.
- R9: While ser_off_i is 1, all serial traffic is ignored, the registers are held at their defaults and sdo_oe_o stays low.
- R10: Writes to addresses 13 to 127 change nothing. Reads from them return 0x00.
- R11: A direction flag of 1 means read and 0 means write. A read leaves the register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset (external power-down) |
| cs_ni | input | 1 | Serial select, active low |
| sclk_i | input | 1 | Serial shift clock |
| sdi_i | input | 1 | Serial data input |
| ser_off_i | input | 1 | Serial interface unused when 1 |
| ctl_pins_i | input | 104 | External control pins, one per register bit |
| sdo_o | output | 1 | Serial data output value |
| sdo_oe_o | output | 1 | Drive enable for the serial output buffer |
| ctl_o | output | 104 | Combined control bits, register i at bits 8*i+7..8*i |
| pdn_no | output | 1 | Combined power-down, active low |
| crst_no | output | 1 | Combined coefficient reset, active low |

## Verification
A bit counter that has slipped appears as a shifted address or data byte within a single frame. It also moves the drive-enable window by one shift-clock period, and the bench checks that window at every bit of every frame. A register-bank state that fails to clear after a power-down, a select abort, or a transfer made while the interface is disabled shows on ctl_o within a few system clocks. Wrong pin combining, including the inverted sense of the two reset bits, shows on ctl_o and the strobes as soon as the pins change.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  localparam int unsigned ADDR_W   = 7;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned CNT_W    = 5;
  localparam int unsigned PDN_BIT  = 7;
  localparam int unsigned CRST_BIT = 6;
  localparam logic [DATA_W-1:0] REG0_DFLT = 8'hC0;

  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= {(STAGES+1){RST_VAL}};
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign q_o    = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/serctl_shifter.sv
module serctl_shifter
  import serctl_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cs_n_i,
  input  logic  sclk_rise_i,
  input  logic  sclk_fall_i,
  input  logic  sdi_i,
  input  logic  ser_off_i,
  input  byte_t rd_data_i,
  output logic  wr_en_o,
  output addr_t addr_o,
  output byte_t wr_data_o,
  output logic  sdo_o,
  output logic  sdo_oe_o
);
  localparam logic [CNT_W-1:0] C_ADDR_END = CNT_W'(1 + ADDR_W);
  localparam logic [CNT_W-1:0] C_LAST     = CNT_W'(ADDR_W + DATA_W);
  localparam logic [CNT_W-1:0] C_DONE     = CNT_W'(1 + ADDR_W + DATA_W);

  logic [CNT_W-1:0]  cnt_q;
  logic              rd_q;
  addr_t             addr_q;
  logic [DATA_W-2:0] dsh_q;
  byte_t             rsh_q;
  byte_t             wdat_q;
  logic              wr_q, oe_q, sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rd_q   <= 1'b0;
      addr_q <= '0;
      dsh_q  <= '0;
      rsh_q  <= '0;
      wdat_q <= '0;
      wr_q   <= 1'b0;
      oe_q   <= 1'b0;
      sdo_q  <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (cs_n_i || ser_off_i) begin
        cnt_q <= '0;
        oe_q  <= 1'b0;
      end else begin
        if (sclk_rise_i && cnt_q != C_DONE) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == '0)             rd_q   <= sdi_i;
          else if (cnt_q < C_ADDR_END) addr_q <= {addr_q[ADDR_W-2:0], sdi_i};
          else if (cnt_q < C_LAST)     dsh_q  <= {dsh_q[DATA_W-3:0], sdi_i};
          else begin
            wdat_q <= {dsh_q, sdi_i};
            wr_q   <= ~rd_q;
          end
        end
        if (sclk_fall_i) begin
          // read data is captured once the address is complete
          if (cnt_q == C_ADDR_END && rd_q) begin
            oe_q  <= 1'b1;
            sdo_q <= rd_data_i[DATA_W-1];
            rsh_q <= {rd_data_i[DATA_W-2:0], 1'b0};
          end else if (oe_q && cnt_q > C_ADDR_END && cnt_q < C_DONE) begin
            sdo_q <= rsh_q[DATA_W-1];
            rsh_q <= {rsh_q[DATA_W-2:0], 1'b0};
          end else begin
            oe_q <= 1'b0;
          end
        end
      end
    end
  end

  assign wr_en_o   = wr_q;
  assign addr_o    = addr_q;
  assign wr_data_o = wdat_q;
  assign sdo_o     = sdo_q;
  assign sdo_oe_o  = oe_q;
endmodule

// File: rtl/serctl_regbank.sv
module serctl_regbank
  import serctl_pkg::*;
#(
  parameter int unsigned NREG = 13,
  localparam int unsigned CTL_W = NREG * DATA_W,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  addr_t            addr_i,
  input  byte_t            wr_data_i,
  input  logic             ser_off_i,
  input  logic [CTL_W-1:0] pins_i,
  output byte_t            rd_data_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic [CTL_W-1:0] regs_flat_o,
  output logic             pdn_no,
  output logic             crst_no
);
  localparam addr_t NREG_A = ADDR_W'(NREG);

  byte_t regs_q [NREG];
  logic  hit;

  assign hit     = addr_i < NREG_A;
  assign pdn_no  = pins_i[PDN_BIT]  & regs_q[0][PDN_BIT];
  assign crst_no = pins_i[CRST_BIT] & regs_q[0][CRST_BIT];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam byte_t DFLT = (i == 0) ? REG0_DFLT : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      regs_q[i] <= DFLT;
      else if (!pdn_no || ser_off_i)    regs_q[i] <= DFLT;
      else if (wr_en_i && hit && addr_i[IDX_W-1:0] == IDX_W'(i))
                                        regs_q[i] <= wr_data_i;
    end

    assign regs_flat_o[i*DATA_W +: DATA_W] = regs_q[i];

    if (i == 0) begin : g_neg
      for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b == PDN_BIT || b == CRST_BIT) begin : g_and
          assign ctl_o[b] = pins_i[b] & regs_q[0][b];
        end else begin : g_or
          assign ctl_o[b] = pins_i[b] | regs_q[0][b];
        end
      end
    end else begin : g_pos
      assign ctl_o[i*DATA_W +: DATA_W] = pins_i[i*DATA_W +: DATA_W] | regs_q[i];
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NREG; i++) begin
      if (hit && addr_i[IDX_W-1:0] == IDX_W'(i)) rd_data_o = regs_q[i];
    end
  end
endmodule

// File: rtl/serial_ctrl_regs.sv
module serial_ctrl_regs
  import serctl_pkg::*;
#(
  parameter int unsigned NREG = 13,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CTL_W = NREG * DATA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sclk_i,
  input  logic             sdi_i,
  input  logic             ser_off_i,
  input  logic [CTL_W-1:0] ctl_pins_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic [CTL_W-1:0] ctl_o,
  output logic             pdn_no,
  output logic             crst_no
);
  logic       sclk_q, sclk_rise, sclk_fall;
  logic       cs_q, cs_rise_unused, cs_fall_unused;
  logic       sdi_q, sdi_rise_unused, sdi_fall_unused;
  logic       wr_en;
  addr_t      addr;
  byte_t      wr_data, rd_data;
  logic [CTL_W-1:0] regs_flat;

  serctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i),
    .q_o(sclk_q), .rise_o(sclk_rise), .fall_o(sclk_fall));

  serctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cs_ni),
    .q_o(cs_q), .rise_o(cs_rise_unused), .fall_o(cs_fall_unused));

  serctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sdi_i),
    .q_o(sdi_q), .rise_o(sdi_rise_unused), .fall_o(sdi_fall_unused));

  serctl_shifter u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_n_i(cs_q),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall), .sdi_i(sdi_q),
    .ser_off_i(ser_off_i), .rd_data_i(rd_data),
    .wr_en_o(wr_en), .addr_o(addr), .wr_data_o(wr_data),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o));

  serctl_regbank #(.NREG(NREG)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wr_data_i(wr_data), .ser_off_i(ser_off_i), .pins_i(ctl_pins_i),
    .rd_data_o(rd_data), .ctl_o(ctl_o), .regs_flat_o(regs_flat),
    .pdn_no(pdn_no), .crst_no(crst_no));
endmodule

// File: rtl/serctl_chk.sv
module serctl_chk
  import serctl_pkg::*;
#(
  parameter int unsigned NREG = 13,
  localparam int unsigned CTL_W = NREG * DATA_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_q,
  input logic             ser_off_i,
  input logic             sdo_oe_o,
  input logic             pdn_no,
  input logic             crst_no,
  input logic             wr_en,
  input addr_t            wr_addr,
  input logic [CTL_W-1:0] regs_flat
);
  localparam addr_t NREG_A = ADDR_W'(NREG);
  localparam logic [CTL_W-1:0] DFLT_FLAT = CTL_W'(REG0_DFLT);

  a_r3_oe_needs_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> !$past(cs_q));

  a_r8_pdn_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdn_no |=> regs_flat == DFLT_FLAT);

  a_r8_crst_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!crst_no && pdn_no && !wr_en && !ser_off_i) |=> $stable(regs_flat));

  a_r9_off_defaults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_off_i |=> regs_flat == DFLT_FLAT);

  a_r9_off_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_off_i |=> !sdo_oe_o);

  a_r10_high_addr_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr >= NREG_A && pdn_no && !ser_off_i) |=> $stable(regs_flat));
endmodule

bind serial_ctrl_regs serctl_chk #(.NREG(NREG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_q(cs_q), .ser_off_i(ser_off_i),
  .sdo_oe_o(sdo_oe_o), .pdn_no(pdn_no), .crst_no(crst_no),
  .wr_en(wr_en), .wr_addr(addr), .regs_flat(regs_flat));

// File: tb/serial_ctrl_regs_tb.sv
module serial_ctrl_regs_tb;
  localparam int CLK_P = 10;
  localparam int NREG  = 13;
  localparam int CTL_W = NREG * 8;

  typedef struct packed {
    logic       rd;
    logic [6:0] a;
    logic [7:0] d;
    logic [7:0] exp;
    logic       split;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 7'd1,   8'hA5, 8'h00, 1'b0},
    '{1'b0, 7'd12,  8'h3C, 8'h00, 1'b1},
    '{1'b0, 7'd5,   8'h81, 8'h00, 1'b0},
    '{1'b1, 7'd1,   8'h00, 8'hA5, 1'b0},
    '{1'b1, 7'd12,  8'h00, 8'h3C, 1'b1},
    '{1'b1, 7'd5,   8'h00, 8'h81, 1'b0},
    '{1'b0, 7'd13,  8'hFF, 8'h00, 1'b0},
    '{1'b1, 7'd13,  8'h00, 8'h00, 1'b0},
    '{1'b1, 7'd0,   8'h00, 8'hC0, 1'b1},
    '{1'b0, 7'd127, 8'h11, 8'h00, 1'b0},
    '{1'b1, 7'd2,   8'h00, 8'h00, 1'b0},
    '{1'b1, 7'd1,   8'h00, 8'hA5, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_ni = 1'b1, sclk = 1'b0, sdi = 1'b0, ser_off = 1'b0;
  logic [CTL_W-1:0] pins = '0;
  logic sdo, sdo_oe, pdn_no, crst_no;
  logic [CTL_W-1:0] ctl;

  int checks = 0;
  int errors = 0;
  logic [7:0] m [NREG];

  always #(CLK_P/2) clk = ~clk;

  serial_ctrl_regs u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .sclk_i(sclk), .sdi_i(sdi),
    .ser_off_i(ser_off), .ctl_pins_i(pins), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .ctl_o(ctl), .pdn_no(pdn_no), .crst_no(crst_no));

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NREG; i++) m[i] = (i == 0) ? 8'hC0 : 8'h00;
  endtask

  function automatic logic [CTL_W-1:0] exp_ctl();
    logic [CTL_W-1:0] r;
    for (int i = 0; i < NREG; i++)
      for (int b = 0; b < 8; b++)
        if (i == 0 && (b == 7 || b == 6)) r[i*8+b] = pins[i*8+b] & m[i][b];
        else                              r[i*8+b] = pins[i*8+b] | m[i][b];
    return r;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // one shift-clock period; samples sdo/oe just before the rising edge
  task automatic send_bit(input logic b, output logic s_sdo, output logic s_oe);
    sdi = b;
    wait_clk(6);
    s_sdo = sdo;
    s_oe  = sdo_oe;
    wait_clk(1);
    sclk = 1'b1;
    wait_clk(8);
    sclk = 1'b0;
  endtask

  task automatic xfer(input logic rd, input logic [6:0] a, input logic [7:0] d,
                      input int gap, output logic [7:0] q, output int oe_bad);
    logic s_sdo, s_oe, b;
    oe_bad = 0;
    q = '0;
    cs_ni = 1'b0;
    wait_clk(4);
    for (int j = 0; j < 16; j++) begin
      b = (j == 0) ? rd : (j < 8) ? a[7-j] : d[15-j];
      if (j == 8 && gap > 0) wait_clk(gap);
      send_bit(b, s_sdo, s_oe);
      if (j >= 8) q[15-j] = s_sdo;
      if (s_oe !== (rd && j >= 8)) oe_bad++;
    end
    wait_clk(6);
    if (sdo_oe !== 1'b0) oe_bad++;
    cs_ni = 1'b1;
    wait_clk(6);
  endtask

  task automatic partial(input int nbits, input logic [15:0] frame);
    logic s_sdo, s_oe;
    cs_ni = 1'b0;
    wait_clk(4);
    for (int j = 0; j < nbits; j++) send_bit(frame[15-j], s_sdo, s_oe);
    wait_clk(4);
    cs_ni = 1'b1;
    wait_clk(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] q;
    int oe_bad;
    string tag;
    model_reset();
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(2);

    // R2: defaults after reset
    check("R2 reset ctl", 128'(ctl), 128'(exp_ctl()));
    check("R7 reset strobes", {126'd0, pdn_no, crst_no}, 128'd0);
    pins[7] = 1'b1; pins[6] = 1'b1;
    wait_clk(1);
    check("R7 strobes idle", {126'd0, pdn_no, crst_no}, 128'd3);
    check("R3 reset oe", 128'(sdo_oe), 128'd0);

    // vector table walk: R1, R3, R4, R10, R11
    for (int v = 0; v < NVEC; v++) begin
      xfer(VEC[v].rd, VEC[v].a, VEC[v].d, VEC[v].split ? 40 : 0, q, oe_bad);
      if (!VEC[v].rd && VEC[v].a < 7'(NREG)) m[VEC[v].a] = VEC[v].d;
      tag = (VEC[v].a >= 7'(NREG)) ? "R10 high address" :
            VEC[v].split ? "R4 split frame" : "R1 R11 frame";
      if (VEC[v].rd) check(tag, 128'(q), 128'(VEC[v].exp));
      check("R3 output window", 128'(oe_bad), 128'd0);
    end
    check("R1 ctl after writes", 128'(ctl), 128'(exp_ctl()));

    // R5: aborted write of 0xFF to register 3 after 12 bits
    partial(12, {1'b0, 7'd3, 8'hFF});
    xfer(1'b1, 7'd3, 8'h00, 0, q, oe_bad);
    check("R5 abort no write", 128'(q), 128'h00);
    xfer(1'b0, 7'd3, 8'h5A, 0, q, oe_bad);
    m[3] = 8'h5A;
    xfer(1'b1, 7'd3, 8'h00, 0, q, oe_bad);
    check("R5 frame after abort", 128'(q), 128'h5A);

    // R6: pins ORed with register bits
    pins[4*8+2] = 1'b1;
    pins[3*8+0] = 1'b1;
    wait_clk(1);
    check("R6 pin or", 128'(ctl), 128'(exp_ctl()));
    pins[4*8+2] = 1'b0;
    pins[3*8+0] = 1'b0;

    // R7/R8: coefficient reset via pin and via bit keeps contents
    pins[6] = 1'b0;
    wait_clk(3);
    check("R7 crst pin", 128'(crst_no), 128'd0);
    check("R8 crst keeps regs", 128'(ctl), 128'(exp_ctl()));
    pins[6] = 1'b1;
    xfer(1'b0, 7'd0, 8'h80, 0, q, oe_bad);
    m[0] = 8'h80;
    check("R7 crst bit", {126'd0, pdn_no, crst_no}, 128'd2);
    check("R8 crst bit keeps regs", 128'(ctl), 128'(exp_ctl()));

    // R8: soft power-down clears the bank and releases itself
    xfer(1'b0, 7'd0, 8'h40, 0, q, oe_bad);
    model_reset();
    check("R8 soft pdn clears", 128'(ctl), 128'(exp_ctl()));
    check("R8 soft pdn released", 128'(pdn_no), 128'd1);

    // R8: power-down pin clears the bank
    xfer(1'b0, 7'd9, 8'h77, 0, q, oe_bad);
    pins[7] = 1'b0;
    wait_clk(3);
    check("R7 pdn pin", 128'(pdn_no), 128'd0);
    pins[7] = 1'b1;
    wait_clk(2);
    xfer(1'b1, 7'd9, 8'h00, 0, q, oe_bad);
    check("R8 pdn pin clears", 128'(q), 128'h00);

    // R9: interface unused
    xfer(1'b0, 7'd2, 8'h3E, 0, q, oe_bad);
    ser_off = 1'b1;
    wait_clk(2);
    check("R9 defaults held", 128'(ctl), 128'(exp_ctl()));
    xfer(1'b0, 7'd4, 8'h55, 0, q, oe_bad);
    check("R9 write ignored", 128'(ctl), 128'(exp_ctl()));
    xfer(1'b1, 7'd0, 8'h00, 0, q, oe_bad);
    check("R9 no drive", 128'(oe_bad), 128'd8);
    ser_off = 1'b0;
    wait_clk(2);
    xfer(1'b1, 7'd2, 8'h00, 0, q, oe_bad);
    check("R9 regs defaulted", 128'(q), 128'h00);

    // R2: hard reset after writes
    xfer(1'b0, 7'd11, 8'hC3, 0, q, oe_bad);
    rst_ni = 1'b0;
    wait_clk(2);
    rst_ni = 1'b1;
    wait_clk(2);
    model_reset();
    check("R2 hard reset", 128'(ctl), 128'(exp_ctl()));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule